// File: doc/BRIEF.md
# Byte-Order Address XOR Adjuster

This block lets a processor work in the byte order opposite to that of a memory system whose order is fixed. It takes the real address of each access and flips some of its low bits. The bits it flips depend on the access size. When both orders agree, every address passes through unchanged. When they disagree, a byte access lands at the mirrored byte within the widest aligned unit, and wider accesses land at their mirrored positions in the same way. The block only adjusts the address. It does not swap data lanes, and it does not split unaligned accesses.

A small table holds one XOR mask per access size. The table is rebuilt whenever software writes the processor's little-endian mode bit. The table entry for the smallest size is the widest access width minus one. The entry for each larger size is the previous entry shifted left by one bit and cut to that same width. Instruction fetches always use the four-byte entry and must be word aligned. If the design is built without the XOR feature, a mode that disagrees with the memory order is not translated. The block raises an error flag instead.

Top module: `endian_addr_xor`

## Requirements
- R1: After reset the mode bit equals the fixed memory order, `order_err` is low and `out_addr` equals `acc_addr` for every size.
- R2: While the mode bit matches the fixed memory order, `out_addr` equals `acc_addr` for every access size and for fetches.
- R3: While the modes conflict, a data access with `acc_size` = 0 (one byte) XORs the address with MAX_BYTES-1, which is 7 for the default of eight bytes.
- R4: While the modes conflict, codes 1, 2 and 3 (two, four and eight bytes) use masks 6, 4 and 0 for the default width. Each is the previous mask shifted left by one and ANDed with MAX_BYTES-1. Address bits at or above log2(MAX_BYTES) are never changed.
- R5: When `acc_fetch` is high, the four-byte mask is applied whatever the value of `acc_size`.
- R6: `fetch_misalign` is high exactly when `acc_fetch` is high and bit 1 or bit 0 of `acc_addr` is set. It stays low for data accesses.
- R7: With XOR_EN = 0, a conflicting mode drives `order_err` high, and `out_addr` equals `acc_addr`. With a matching mode, `order_err` is low.
- R8: A mode write (`mode_wr` high) takes effect at the next rising clock edge. Accesses in the same cycle as the write still use the old table. Accesses in the following cycle use the new table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the processor mode bit |
| mode_le_in | input | 1 | New processor mode (1 = little-endian) |
| acc_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_addr | input | ADDR_W | Real address before adjustment |
| out_addr | output | ADDR_W | Adjusted real address |
| fetch_misalign | output | 1 | Fetch address is not word aligned |
| order_err | output | 1 | Conflicting mode while the XOR feature is absent |

## Verification
The main function is tried in both mode states with every size code, at one address with all low bits set and one with all low bits clear.

- The all-set address shows which bits each mask flips. This separates the masks 7, 6, 4 and 0 from one another and from pass-through.
- The all-clear address shows that no bit above the lane field is disturbed.

Fetches are issued with every size code, to show that the size code is ignored in favour of the four-byte entry. Fetches and data accesses are both issued with misaligned low bits, so that the misalignment flag is tied to fetches only.

A mode write is sampled both in its own cycle and in the cycle after. This separates a table that updates at the clock edge from one that updates combinationally or one cycle late. A second instance built without the XOR feature shows that the error flag is raised, and the address is not altered, only when the modes conflict.

// File: rtl/endian_xor_pkg.sv
// Package: shared size codes and helper for the byte-order address adjuster.
// Assumes access sizes are powers of two from one byte up to MAX_BYTES.
package endian_xor_pkg;

    // Encoded access size; the code is log2 of the byte count.
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // Table index used for instruction fetches (four-byte entry).
    localparam int unsigned FETCH_SIZE_IDX = 2;

endpackage

// File: rtl/exa_mode_reg.sv
// Module: holds the processor's little-endian mode bit.
// Assumes a write strobe with the new value; reset loads the memory order,
// so that the block starts with matching orders.
module exa_mode_reg #(
    parameter bit MEM_LITTLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_le,
    output logic le_q,
    output logic le_next
);

    // Next mode value: a write replaces it, otherwise it holds.
    always_comb begin
        le_next = wr_en ? wr_le : le_q;
    end

    // Mode register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            le_q <= MEM_LITTLE;
        end else begin
            le_q <= le_next;
        end
    end

endmodule

// File: rtl/exa_mask_table.sv
// Module: registered table with one XOR mask per access size, and the order
// error flag. The table is rebuilt from the next mode value, so it changes at
// the same clock edge as the mode register.
// Assumes MAX_BYTES is a power of two and at least 4.
module exa_mask_table #(
    parameter int unsigned MAX_BYTES  = 8,
    parameter bit          MEM_LITTLE = 1'b0,
    parameter bit          XOR_EN     = 1'b1,
    localparam int unsigned LANE_W    = $clog2(MAX_BYTES),
    localparam int unsigned NUM_SIZES = LANE_W + 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                le_next,
    output logic [NUM_SIZES-1:0][LANE_W-1:0]    masks,
    output logic                                order_err
);

    localparam logic [LANE_W-1:0] LANE_LIMIT = LANE_W'(MAX_BYTES - 1);

    logic conflict_next;

    // Detect whether the incoming mode disagrees with the memory order.
    always_comb begin
        conflict_next = (le_next != MEM_LITTLE);
    end

    generate
        if (XOR_EN) begin : g_xor
            for (genvar k = 0; k < NUM_SIZES; k++) begin : g_entry
                logic [LANE_W-1:0] entry_q;

                // Entry k: base mask shifted left by k, cut to lane width.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        entry_q <= '0;
                    end else begin
                        entry_q <= conflict_next ?
                                   (LANE_LIMIT << k) & LANE_LIMIT : '0;
                    end
                end

                assign masks[k] = entry_q;
            end
            assign order_err = 1'b0;
        end else begin : g_noxor
            logic err_q;

            // Without the XOR feature, a conflicting mode raises the error flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    err_q <= 1'b0;
                end else begin
                    err_q <= conflict_next;
                end
            end

            assign masks     = '0;
            assign order_err = err_q;
        end
    endgenerate

endmodule

// File: rtl/exa_addr_apply.sv
// Module: combinational address adjustment. Selects a mask by access size
// (or the four-byte entry for fetches) and XORs it into the low address bits.
// Assumes the size code is log2 of the byte count.
module exa_addr_apply
    import endian_xor_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MAX_BYTES = 8,
    localparam int unsigned LANE_W    = $clog2(MAX_BYTES),
    localparam int unsigned NUM_SIZES = LANE_W + 1
) (
    input  logic [ADDR_W-1:0]                   addr_in,
    input  logic [1:0]                          size_code,
    input  logic                                is_fetch,
    input  logic [NUM_SIZES-1:0][LANE_W-1:0]    masks,
    output logic [ADDR_W-1:0]                   addr_out,
    output logic                                misalign
);

    logic [1:0]        idx;
    logic [LANE_W-1:0] sel_mask;

    // Choose the table index: fetches always use the four-byte entry.
    always_comb begin
        idx = is_fetch ? 2'(FETCH_SIZE_IDX) : size_code;
    end

    // Look up the mask; a code beyond the table selects no flip.
    always_comb begin
        sel_mask = '0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (int'(idx) == i) begin
                sel_mask = masks[i];
            end
        end
    end

    // Flip the low lane bits and keep the upper bits as they are.
    always_comb begin
        addr_out = {addr_in[ADDR_W-1:LANE_W], addr_in[LANE_W-1:0] ^ sel_mask};
    end

    // A fetch must be word aligned.
    always_comb begin
        misalign = is_fetch && (addr_in[1:0] != 2'b00);
    end

endmodule

// File: rtl/endian_addr_xor.sv
// Top: byte-order address XOR adjuster. Combines the mode register, the
// registered mask table and the combinational address adjustment.
// Assumes MAX_BYTES is a power of two between 4 and 8, so that the 2-bit size
// code covers every table entry.
module endian_addr_xor #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned MAX_BYTES  = 8,
    parameter bit          MEM_LITTLE = 1'b0,
    parameter bit          XOR_EN     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_le_in,
    input  logic [1:0]        acc_size,
    input  logic              acc_fetch,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] out_addr,
    output logic              fetch_misalign,
    output logic              order_err
);

    localparam int unsigned LANE_W    = $clog2(MAX_BYTES);
    localparam int unsigned NUM_SIZES = LANE_W + 1;

    logic                             le_q;
    logic                             le_next;
    logic [NUM_SIZES-1:0][LANE_W-1:0] masks;

    exa_mode_reg #(.MEM_LITTLE(MEM_LITTLE)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_le   (mode_le_in),
        .le_q    (le_q),
        .le_next (le_next)
    );

    exa_mask_table #(
        .MAX_BYTES  (MAX_BYTES),
        .MEM_LITTLE (MEM_LITTLE),
        .XOR_EN     (XOR_EN)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .le_next   (le_next),
        .masks     (masks),
        .order_err (order_err)
    );

    exa_addr_apply #(
        .ADDR_W    (ADDR_W),
        .MAX_BYTES (MAX_BYTES)
    ) u_apply (
        .addr_in   (acc_addr),
        .size_code (acc_size),
        .is_fetch  (acc_fetch),
        .masks     (masks),
        .addr_out  (out_addr),
        .misalign  (fetch_misalign)
    );

    // The mode register value is held for the table; only le_next feeds logic.
    logic unused_le;
    assign unused_le = le_q;

endmodule

// File: rtl/endian_addr_xor_chk.sv
// Checker: port-level properties of the byte-order address adjuster,
// attached to every instance of the top module through bind.
module endian_addr_xor_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned MAX_BYTES  = 8,
    parameter bit          MEM_LITTLE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic              mode_le_in,
    input logic [1:0]        acc_size,
    input logic              acc_fetch,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [ADDR_W-1:0] out_addr,
    input logic              fetch_misalign,
    input logic              order_err
);

    localparam int unsigned LANE_W = $clog2(MAX_BYTES);

    // R1
    reset_pass_chk: assert property (@(posedge clk)
        !rst_n |=> (out_addr == acc_addr) && !order_err);

    // R4
    upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_addr[ADDR_W-1:LANE_W] == acc_addr[ADDR_W-1:LANE_W]);

    // R4
    widest_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'd3 && !acc_fetch) |-> out_addr == acc_addr);

    // R5
    fetch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fetch |-> out_addr[1:0] == acc_addr[1:0]);

    // R6
    misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_misalign == (acc_fetch && acc_addr[1:0] != 2'b00));

    // R7
    err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |-> out_addr == acc_addr);

    // R8
    match_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_le_in == MEM_LITTLE) |=> (out_addr == acc_addr) && !order_err);

endmodule

bind endian_addr_xor endian_addr_xor_chk #(
    .ADDR_W     (ADDR_W),
    .MAX_BYTES  (MAX_BYTES),
    .MEM_LITTLE (MEM_LITTLE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_wr        (mode_wr),
    .mode_le_in     (mode_le_in),
    .acc_size       (acc_size),
    .acc_fetch      (acc_fetch),
    .acc_addr       (acc_addr),
    .out_addr       (out_addr),
    .fetch_misalign (fetch_misalign),
    .order_err      (order_err)
);

// File: tb/test_endian_addr_xor.sv
// Bench: directed tests, one task per scenario, for the byte-order adjuster.
module test_endian_addr_xor;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned MAX_BYTES = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_wr = 1'b0;
    logic              mode_le_in = 1'b0;
    logic [1:0]        acc_size = 2'd0;
    logic              acc_fetch = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [ADDR_W-1:0] out_addr, out_addr_nx;
    logic              fetch_misalign, fetch_misalign_nx;
    logic              order_err, order_err_nx;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    endian_addr_xor #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES),
                      .MEM_LITTLE(1'b0), .XOR_EN(1'b1)) i_endian_addr_xor (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_le_in(mode_le_in),
        .acc_size(acc_size), .acc_fetch(acc_fetch), .acc_addr(acc_addr),
        .out_addr(out_addr), .fetch_misalign(fetch_misalign), .order_err(order_err)
    );

    endian_addr_xor #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES),
                      .MEM_LITTLE(1'b0), .XOR_EN(1'b0)) i_endian_addr_xor_noxor (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_le_in(mode_le_in),
        .acc_size(acc_size), .acc_fetch(acc_fetch), .acc_addr(acc_addr),
        .out_addr(out_addr_nx), .fetch_misalign(fetch_misalign_nx),
        .order_err(order_err_nx)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic [ADDR_W-1:0] got,
                       input logic [ADDR_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Mask the requirements give for a size code under conflict.
    function automatic logic [ADDR_W-1:0] conflict_mask(input int code);
        case (code)
            0: return 32'd7;
            1: return 32'd6;
            2: return 32'd4;
            default: return 32'd0;
        endcase
    endfunction

    // Set access inputs at the falling edge, then sample just after.
    task automatic access(input logic [1:0] sz, input logic f, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        acc_size = sz; acc_fetch = f; acc_addr = a;
        #1;
    endtask

    // Write the mode bit over one rising edge.
    task automatic write_mode(input logic le);
        @(negedge clk);
        mode_wr = 1'b1; mode_le_in = le;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    // R1: reset state passes addresses through with no error.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            access(2'(s), 1'b0, 32'h1234_5677);
            chk("R1 pass after reset", out_addr, 32'h1234_5677);
        end
        chk("R1 no error after reset", {31'd0, order_err_nx}, 32'd0);
    endtask

    // R2: matching mode leaves every size and fetches unchanged.
    task automatic t_match();
        write_mode(1'b0);
        for (int s = 0; s < 4; s++) begin
            access(2'(s), 1'b0, 32'hABCD_EF07);
            chk("R2 match data", out_addr, 32'hABCD_EF07);
        end
        access(2'd0, 1'b1, 32'h0000_0104);
        chk("R2 match fetch", out_addr, 32'h0000_0104);
    endtask

    // R3/R4: conflicting mode masks for each size, two addresses.
    task automatic t_conflict();
        write_mode(1'b1);
        for (int s = 0; s < 4; s++) begin
            access(2'(s), 1'b0, 32'h8000_00FF);
            chk(s == 0 ? "R3 byte mask" : "R4 wider mask",
                out_addr, 32'h8000_00FF ^ conflict_mask(s));
            access(2'(s), 1'b0, 32'h7FFF_FF00);
            chk("R4 upper bits and flips", out_addr, 32'h7FFF_FF00 ^ conflict_mask(s));
            chk("R4 masks from shift", conflict_mask(s), 32'((7 << s) & 7));
        end
    endtask

    // R5/R6: fetches use the four-byte entry and flag misalignment.
    task automatic t_fetch();
        for (int s = 0; s < 4; s++) begin
            access(2'(s), 1'b1, 32'h0000_2000);
            chk("R5 fetch uses size-4 mask", out_addr, 32'h0000_2004);
            chk("R6 aligned fetch", {31'd0, fetch_misalign}, 32'd0);
        end
        access(2'd2, 1'b1, 32'h0000_2002);
        chk("R6 misaligned fetch", {31'd0, fetch_misalign}, 32'd1);
        access(2'd0, 1'b0, 32'h0000_2003);
        chk("R6 data never flagged", {31'd0, fetch_misalign}, 32'd0);
    endtask

    // R8: a write does not affect its own cycle, only the next one.
    task automatic t_switch();
        @(negedge clk);
        mode_wr = 1'b1; mode_le_in = 1'b0;
        acc_size = 2'd0; acc_fetch = 1'b0; acc_addr = 32'h0000_0010;
        #1;
        chk("R8 old table during write", out_addr, 32'h0000_0017);
        @(negedge clk);
        mode_wr = 1'b0;
        #1;
        chk("R8 new table after write", out_addr, 32'h0000_0010);
    endtask

    // R7: without XOR, conflict raises the error and passes the address.
    task automatic t_noxor();
        write_mode(1'b1);
        access(2'd0, 1'b0, 32'h0000_0051);
        chk("R7 error on conflict", {31'd0, order_err_nx}, 32'd1);
        chk("R7 no translation", out_addr_nx, 32'h0000_0051);
        write_mode(1'b0);
        access(2'd0, 1'b0, 32'h0000_0051);
        chk("R7 error clear on match", {31'd0, order_err_nx}, 32'd0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Main sequence.
    initial begin
        t_reset();
        t_match();
        t_conflict();
        t_fetch();
        t_switch();
        t_noxor();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule